// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Acknowledge Unit

This block joins two eight-line interrupt controllers, a primary and a secondary, into one system with fifteen usable request sources and a single interrupt line to the processor. Whenever the secondary controller has a request that it could present, the unit sets pending bit 2 in the primary controller. Primary line 2 is therefore the cascade input, and request pin 2 of the block is not connected to anything.

When the processor acknowledges, the primary controller resolves first. If its winner is the cascade line, the secondary controller then resolves as well, and the unit returns an 8-bit vector. If no line is pending at a given level, the vector for line 7 at that level is returned instead.

The controllers are programmed over a simple byte-wide I/O bus. Each controller has a command port and a mask port. Two trigger-mode registers select edge or level sensing for each line.

Top module: `icu_cascade`

## Requirements
- R1: After reset `cpu_int` and `ack_vld` are low. Every mask, pending, in-service and trigger-mode register reads 0. The primary base is 0x08 and the secondary base is 0x70.
- R2: An edge-mode line becomes pending on a rising input, and `cpu_int` is high on the first clock after that input is sampled. A line held high is not latched again after it has been acknowledged.
- R3: When the primary winner is not line 2, acknowledge returns the primary base plus the line number, where line 0 has the highest priority. The line's in-service bit is set and its edge-mode pending bit is cleared.
- R4: A presentable secondary request sets primary pending bit 2 one clock later, so `cpu_int` rises on the second clock after the input. Acknowledge then returns the secondary base plus the secondary line and sets in-service bit 2 in the primary and the line's bit in the secondary. `irq_in[2]` is ignored.
- R5: Acknowledge with nothing presentable on the primary returns the primary base plus 7 and changes no state.
- R6: When the primary winner is line 2 but the secondary has nothing pending, acknowledge returns the secondary base plus 7 and leaves the secondary's in-service register unchanged.
- R7: `ack_vld` and `ack_vector` are valid exactly one clock after `ack_req`, and `cpu_int` is low in that cycle.
- R8: A line in level mode (trigger bit 1) is pending while its input is high, stays pending when acknowledged, and stops being pending once the input drops. The writable trigger bits are 0xF8 for the primary and 0xDE for the secondary.
- R9: A line whose mask bit is 1 does not raise `cpu_int` but keeps its pending bit. The mask reads back from the mask port.
- R10: A pending line of equal or lower priority than the highest in-service line does not raise `cpu_int`. Command 001xxxxx clears the highest-priority in-service bit, and command 011xxLLL clears in-service bit LLL.
- R11: The primary is at 0x20 (command) and 0x21 (mask), the secondary at 0xA0 and 0xA1, and the trigger registers at 0x4D0 (primary) and 0x4D1 (secondary). Only `bus_size`=0 (single byte) accesses are honoured; other sizes are ignored on write and read 0. Reads of unmapped addresses return 0. Read data is valid one clock after `bus_rd`.
- R12: Command 110xxxxx arms a poll. The next command-port read returns 0x80|line and clears that line's pending and in-service bits, or returns 0x07 if nothing is presentable. A secondary poll that finds a line also clears primary pending bit 2 and in-service bit 2.
- R13: Command 010BBBBB sets the controller's vector base to {BBBBB,000}. Command 100xxxxS selects what the command port reads: the in-service register when S=1, the pending register when S=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; [7:0] primary, [15:8] secondary; bit 2 unused |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack_req | input | 1 | Acknowledge request pulse |
| ack_vld | output | 1 | Vector valid, one clock after `ack_req` |
| ack_vector | output | 8 | Acknowledged vector |
| bus_addr | input | 16 | I/O address |
| bus_size | input | 2 | Access size minus one; 0 means one byte |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after `bus_rd` |

## Verification
A change on a primary input shows up on `cpu_int` after one clock edge. A change on a secondary input needs two edges, because it must first pass through primary pending bit 2, and the bench checks that `cpu_int` is still low after the first edge. Acknowledge results and bus read data are due one edge after their strobe. Every register write takes effect at the edge on which it is presented. The bench drives each strobe right after a falling edge and samples at the next falling edge, so each check falls in the cycle where its result is due.

// File: rtl/icu_pkg.sv
package icu_pkg;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } pick_t;

  // command opcodes in bits [7:5] of a command-port write
  localparam logic [2:0] OP_EOI_ANY  = 3'b001;
  localparam logic [2:0] OP_SET_BASE = 3'b010;
  localparam logic [2:0] OP_EOI_LINE = 3'b011;
  localparam logic [2:0] OP_RD_SEL   = 3'b100;
  localparam logic [2:0] OP_POLL     = 3'b110;

  typedef enum logic [2:0] {
    RS_NONE, RS_M_CMD, RS_M_MASK, RS_S_CMD, RS_S_MASK, RS_M_TRIG, RS_S_TRIG
  } rd_src_t;

  // lowest set index wins (fixed priority, line 0 highest)
  function automatic pick_t pick_first(input logic [7:0] v);
    pick_t r;
    r.hit = 1'b0;
    r.idx = 3'd0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.idx = 3'(i);
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] make_vector(input logic [7:0] base, input logic [2:0] line);
    return {base[7:3], line};
  endfunction

endpackage

// File: rtl/icu_ctrl8.sv
module icu_ctrl8 import icu_pkg::*; #(
  parameter logic [7:0] TRIG_WMASK = 8'hFF,
  parameter logic [7:0] BASE_RST   = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] req,
  input  logic [7:0] cas_set,
  input  logic [7:0] clr_vec,
  input  logic       cmd_we,
  input  logic       mask_we,
  input  logic       trig_we,
  input  logic [7:0] wdata,
  input  logic       cmd_rd,
  input  logic       ack_take,
  output logic       present,
  output logic [2:0] winner,
  output logic [7:0] base,
  output logic [7:0] imr_out,
  output logic [7:0] trig_out,
  output logic [7:0] rd0_data,
  output logic       poll_hit
);

  logic [7:0] irr_q, isr_q, imr_q, trig_q, lvl_q, base_q;
  logic [7:0] irr_d, isr_d;
  logic       sel_isr_q, poll_q;
  pick_t      pend_pk, svc_pk;

  assign pend_pk  = pick_first(irr_q & ~imr_q);
  assign svc_pk   = pick_first(isr_q);
  assign present  = pend_pk.hit && (!svc_pk.hit || (pend_pk.idx < svc_pk.idx));
  assign winner   = pend_pk.idx;
  assign poll_hit = cmd_rd && poll_q && present;
  assign base     = base_q;
  assign imr_out  = imr_q;
  assign trig_out = trig_q;

  always_comb begin
    if (poll_q)
      rd0_data = present ? {5'b10000, pend_pk.idx} : 8'h07;
    else
      rd0_data = sel_isr_q ? isr_q : irr_q;
  end

  always_comb begin
    irr_d = (trig_q & req) | (~trig_q & (irr_q | (req & ~lvl_q))) | cas_set;
    isr_d = isr_q;
    if (ack_take) begin
      isr_d[winner] = 1'b1;
      if (!trig_q[winner]) irr_d[winner] = 1'b0;
    end
    if (poll_hit) begin
      irr_d[winner] = 1'b0;
      isr_d[winner] = 1'b0;
    end
    if (cmd_we) begin
      case (wdata[7:5])
        OP_EOI_ANY:  if (svc_pk.hit) isr_d[svc_pk.idx] = 1'b0;
        OP_EOI_LINE: isr_d[wdata[2:0]] = 1'b0;
        default: ;
      endcase
    end
    irr_d = irr_d & ~clr_vec;
    isr_d = isr_d & ~clr_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q     <= '0;
      isr_q     <= '0;
      imr_q     <= '0;
      trig_q    <= '0;
      lvl_q     <= '0;
      base_q    <= BASE_RST;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      lvl_q <= req;
      if (mask_we) imr_q <= wdata;
      if (trig_we) trig_q <= wdata & TRIG_WMASK;
      if (cmd_rd) poll_q <= 1'b0;
      if (cmd_we) begin
        case (wdata[7:5])
          OP_SET_BASE: base_q <= {wdata[4:0], 3'b000};
          OP_RD_SEL:   sel_isr_q <= wdata[0];
          OP_POLL:     poll_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R3: a new in-service bit only appears after an acknowledge take
  p_isr_set_by_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr_q & ~$past(isr_q))) |-> $past(ack_take));

  // R8: a level-mode winner remains pending across its acknowledge
  p_level_keeps_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && trig_q[winner] && req[winner] && clr_vec == 8'h00) |=> irr_q[$past(winner)]);

  // R12: an edge-mode line found by a poll is no longer pending afterwards
  p_poll_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_hit && !trig_q[winner] && cas_set == 8'h00) |=> !irr_q[$past(winner)]);

endmodule

// File: rtl/icu_bus_dec.sv
module icu_bus_dec import icu_pkg::*; #(
  parameter logic [15:0] M_ADDR  = 16'h0020,
  parameter logic [15:0] S_ADDR  = 16'h00A0,
  parameter logic [15:0] TR_ADDR = 16'h04D0
) (
  input  logic [15:0] addr,
  input  logic [1:0]  size,
  input  logic        wr,
  input  logic        rd,
  output logic        m_cmd_we,
  output logic        m_mask_we,
  output logic        s_cmd_we,
  output logic        s_mask_we,
  output logic        m_trig_we,
  output logic        s_trig_we,
  output logic        m_cmd_rd,
  output logic        s_cmd_rd,
  output rd_src_t     rd_src
);

  localparam logic [14:0] M_PAIR  = M_ADDR[15:1];
  localparam logic [14:0] S_PAIR  = S_ADDR[15:1];
  localparam logic [14:0] TR_PAIR = TR_ADDR[15:1];

  logic    byte_ok;
  rd_src_t hit_src;

  assign byte_ok = (size == 2'd0);

  always_comb begin
    hit_src = RS_NONE;
    if (addr[15:1] == M_PAIR)       hit_src = addr[0] ? RS_M_MASK : RS_M_CMD;
    else if (addr[15:1] == S_PAIR)  hit_src = addr[0] ? RS_S_MASK : RS_S_CMD;
    else if (addr[15:1] == TR_PAIR) hit_src = addr[0] ? RS_S_TRIG : RS_M_TRIG;
  end

  assign m_cmd_we  = wr && byte_ok && hit_src == RS_M_CMD;
  assign m_mask_we = wr && byte_ok && hit_src == RS_M_MASK;
  assign s_cmd_we  = wr && byte_ok && hit_src == RS_S_CMD;
  assign s_mask_we = wr && byte_ok && hit_src == RS_S_MASK;
  assign m_trig_we = wr && byte_ok && hit_src == RS_M_TRIG;
  assign s_trig_we = wr && byte_ok && hit_src == RS_S_TRIG;
  assign m_cmd_rd  = rd && byte_ok && hit_src == RS_M_CMD;
  assign s_cmd_rd  = rd && byte_ok && hit_src == RS_S_CMD;
  assign rd_src    = (rd && byte_ok) ? hit_src : RS_NONE;

  // R11: at most one register is written per access
  always_comb begin
    a_one_write_r11: assert ($onehot0({m_cmd_we, m_mask_we, s_cmd_we, s_mask_we, m_trig_we, s_trig_we}));
  end

endmodule

// File: rtl/icu_ack_seq.sv
module icu_ack_seq import icu_pkg::*; #(
  parameter logic [2:0] CAS_LINE  = 3'd2,
  parameter logic [2:0] SPUR_LINE = 3'd7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_req,
  input  logic       m_present,
  input  logic [2:0] m_win,
  input  logic [7:0] m_base,
  input  logic       s_present,
  input  logic [2:0] s_win,
  input  logic [7:0] s_base,
  output logic       m_take,
  output logic       s_take,
  output logic       ack_vld,
  output logic [7:0] vector
);

  logic       cas_hit;
  logic [7:0] vec_d;

  assign m_take  = ack_req && m_present;
  assign cas_hit = m_take && (m_win == CAS_LINE);
  assign s_take  = cas_hit && s_present;

  always_comb begin
    if (!m_present)   vec_d = make_vector(m_base, SPUR_LINE);
    else if (cas_hit) vec_d = make_vector(s_base, s_present ? s_win : SPUR_LINE);
    else              vec_d = make_vector(m_base, m_win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_vld <= 1'b0;
      vector  <= '0;
    end else begin
      ack_vld <= ack_req;
      if (ack_req) vector <= vec_d;
    end
  end

  // R5: acknowledge with no primary request ends on line 7
  p_spur_primary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !m_present) |=> (vector[2:0] == SPUR_LINE && vector[7:3] == $past(m_base[7:3])));

  // R6: an empty secondary is never taken
  p_spur_secondary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_hit && !s_present) |=> (vector[2:0] == SPUR_LINE));

endmodule

// File: rtl/icu_cascade.sv
module icu_cascade import icu_pkg::*; #(
  parameter logic [7:0]  M_TRIG_WMASK = 8'hF8,
  parameter logic [7:0]  S_TRIG_WMASK = 8'hDE,
  parameter logic [7:0]  M_BASE_RST   = 8'h08,
  parameter logic [7:0]  S_BASE_RST   = 8'h70,
  parameter logic [2:0]  CAS_LINE     = 3'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  output logic        cpu_int,
  input  logic        ack_req,
  output logic        ack_vld,
  output logic [7:0]  ack_vector,
  input  logic [15:0] bus_addr,
  input  logic [1:0]  bus_size,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata
);

  localparam logic [7:0] CAS_BIT = 8'(1) << CAS_LINE;

  logic       m_cmd_we, m_mask_we, s_cmd_we, s_mask_we, m_trig_we, s_trig_we;
  logic       m_cmd_rd, s_cmd_rd;
  rd_src_t    rd_src;
  logic       m_present, s_present, m_take, s_take, m_poll_hit, s_poll_hit;
  logic [2:0] m_win, s_win;
  logic [7:0] m_base, s_base, m_imr, s_imr, m_trig, s_trig, m_rd0, s_rd0;
  logic [7:0] m_req, cas_set, m_clr;
  logic [7:0] rd_mux;

  assign m_req   = irq_in[7:0] & ~CAS_BIT;
  assign cas_set = (s_present && !ack_req && !s_poll_hit) ? CAS_BIT : 8'h00;
  assign m_clr   = s_poll_hit ? CAS_BIT : 8'h00;

  icu_bus_dec u_dec (
    .addr(bus_addr), .size(bus_size), .wr(bus_wr), .rd(bus_rd),
    .m_cmd_we(m_cmd_we), .m_mask_we(m_mask_we), .s_cmd_we(s_cmd_we), .s_mask_we(s_mask_we),
    .m_trig_we(m_trig_we), .s_trig_we(s_trig_we), .m_cmd_rd(m_cmd_rd), .s_cmd_rd(s_cmd_rd),
    .rd_src(rd_src)
  );

  icu_ctrl8 #(.TRIG_WMASK(M_TRIG_WMASK), .BASE_RST(M_BASE_RST)) u_prim (
    .clk(clk), .rst_n(rst_n), .req(m_req), .cas_set(cas_set), .clr_vec(m_clr),
    .cmd_we(m_cmd_we), .mask_we(m_mask_we), .trig_we(m_trig_we), .wdata(bus_wdata),
    .cmd_rd(m_cmd_rd), .ack_take(m_take), .present(m_present), .winner(m_win),
    .base(m_base), .imr_out(m_imr), .trig_out(m_trig), .rd0_data(m_rd0), .poll_hit(m_poll_hit)
  );

  icu_ctrl8 #(.TRIG_WMASK(S_TRIG_WMASK), .BASE_RST(S_BASE_RST)) u_sec (
    .clk(clk), .rst_n(rst_n), .req(irq_in[15:8]), .cas_set(8'h00), .clr_vec(8'h00),
    .cmd_we(s_cmd_we), .mask_we(s_mask_we), .trig_we(s_trig_we), .wdata(bus_wdata),
    .cmd_rd(s_cmd_rd), .ack_take(s_take), .present(s_present), .winner(s_win),
    .base(s_base), .imr_out(s_imr), .trig_out(s_trig), .rd0_data(s_rd0), .poll_hit(s_poll_hit)
  );

  icu_ack_seq #(.CAS_LINE(CAS_LINE)) u_ack (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req),
    .m_present(m_present), .m_win(m_win), .m_base(m_base),
    .s_present(s_present), .s_win(s_win), .s_base(s_base),
    .m_take(m_take), .s_take(s_take), .ack_vld(ack_vld), .vector(ack_vector)
  );

  always_comb begin
    case (rd_src)
      RS_M_CMD:  rd_mux = m_rd0;
      RS_M_MASK: rd_mux = m_imr;
      RS_S_CMD:  rd_mux = s_rd0;
      RS_S_MASK: rd_mux = s_imr;
      RS_M_TRIG: rd_mux = m_trig;
      RS_S_TRIG: rd_mux = s_trig;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  assign cpu_int = m_present && !ack_vld;

  // R7: the vector arrives one clock after the request
  p_ack_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_vld);

  // R7: no interrupt request while the vector is on the port
  p_int_quiet_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> !cpu_int);

  // R4: a secondary take always rides on a primary take
  p_sec_take_via_prim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_take |-> m_take);

endmodule

// File: tb/sim_icu_cascade.sv
module sim_icu_cascade;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic        cpu_int;
  logic        ack_req = 1'b0;
  logic        ack_vld;
  logic [7:0]  ack_vector;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  icu_cascade u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_int(cpu_int),
    .ack_req(ack_req), .ack_vld(ack_vld), .ack_vector(ack_vector),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {line, expected vector} for primary edge-mode lines with base 0x08
  localparam logic [15:0] LINE_TBL [7] = '{
    16'h0008, 16'h0109, 16'h030B, 16'h040C, 16'h050D, 16'h060E, 16'h070F
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_size = 2'd0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, input logic [1:0] sz = 2'd0);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0; bus_size = 2'd0;
    d = bus_rdata;
  endtask

  task automatic ack(output logic [7:0] vec);
    ack_req = 1'b1;
    step();
    ack_req = 1'b0;
    chk("R7 ack_vld", {7'd0, ack_vld}, 8'h01);
    chk("R7 cpu_int low in ack", {7'd0, cpu_int}, 8'h00);
    vec = ack_vector;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 cpu_int", {7'd0, cpu_int}, 8'h00);
    chk("R1 ack_vld", {7'd0, ack_vld}, 8'h00);
    rd(16'h0020, v); chk("R1 primary pending", v, 8'h00);
    rd(16'h00A1, v); chk("R1 secondary mask", v, 8'h00);
    rd(16'h04D0, v); chk("R1 primary trigger", v, 8'h00);

    // table walk: R2, R3 on every non-cascade primary line
    for (int k = 0; k < 7; k++) begin
      irq_in[LINE_TBL[k][11:8]] = 1'b1;
      step();
      chk("R2 cpu_int after edge", {7'd0, cpu_int}, 8'h01);
      ack(v);
      chk("R3 primary vector", v, LINE_TBL[k][7:0]);
      step();
      chk("R10 cpu_int while in service", {7'd0, cpu_int}, 8'h00);
      wr(16'h0020, 8'h20);
      irq_in[LINE_TBL[k][11:8]] = 1'b0;
      step();
    end

    // R8 trigger register writable bits
    wr(16'h04D0, 8'hFF); rd(16'h04D0, v); chk("R8 primary trig mask", v, 8'hF8);
    wr(16'h04D1, 8'hFF); rd(16'h04D1, v); chk("R8 secondary trig mask", v, 8'hDE);
    wr(16'h04D0, 8'h00); wr(16'h04D1, 8'h00);

    // R11 sizes and decode
    wr(16'h0021, 8'h55, 2'd1); rd(16'h0021, v); chk("R11 wide write ignored", v, 8'h00);
    wr(16'h0021, 8'h55);       rd(16'h0021, v, 2'd2); chk("R11 wide read zero", v, 8'h00);
    rd(16'h0021, v); chk("R11 byte read", v, 8'h55);
    wr(16'h0021, 8'h00);
    wr(16'h00A1, 8'h3C); rd(16'h00A1, v); chk("R11 secondary mask port", v, 8'h3C);
    wr(16'h00A1, 8'h00);
    rd(16'h0022, v); chk("R11 unmapped read", v, 8'h00);

    // R3/R10 priority and nesting, R2 no relatch
    irq_in[5] = 1'b1; irq_in[3] = 1'b1;
    step();
    ack(v); chk("R3 lowest line wins", v, 8'h0B);
    step();
    chk("R10 lower line blocked", {7'd0, cpu_int}, 8'h00);
    wr(16'h0020, 8'h20);
    chk("R10 after EOI", {7'd0, cpu_int}, 8'h01);
    ack(v); chk("R3 second line", v, 8'h0D);
    wr(16'h0020, 8'h20);
    chk("R2 held line not relatched", {7'd0, cpu_int}, 8'h00);
    irq_in[5] = 1'b0; irq_in[3] = 1'b0;
    step();

    // R9 mask
    wr(16'h0021, 8'h01);
    irq_in[0] = 1'b1;
    step();
    chk("R9 masked line quiet", {7'd0, cpu_int}, 8'h00);
    rd(16'h0021, v); chk("R9 mask readback", v, 8'h01);
    wr(16'h0021, 8'h00);
    chk("R9 pending kept", {7'd0, cpu_int}, 8'h01);
    ack(v); chk("R9 vector after unmask", v, 8'h08);
    wr(16'h0020, 8'h20);
    irq_in[0] = 1'b0;
    step();

    // R5 spurious primary
    ack(v); chk("R5 spurious primary", v, 8'h0F);
    wr(16'h0020, 8'h81); rd(16'h0020, v); chk("R5 in-service unchanged", v, 8'h00);
    wr(16'h0020, 8'h80);

    // R4 cascade
    irq_in[2] = 1'b1;
    step();
    chk("R4 irq_in[2] ignored", {7'd0, cpu_int}, 8'h00);
    irq_in[2] = 1'b0;
    irq_in[12] = 1'b1;
    step();
    chk("R4 not yet at primary", {7'd0, cpu_int}, 8'h00);
    step();
    chk("R4 cpu_int second clock", {7'd0, cpu_int}, 8'h01);
    ack(v); chk("R4 secondary vector", v, 8'h74);
    wr(16'h0020, 8'h81); rd(16'h0020, v); chk("R4 primary in-service", v, 8'h04);
    wr(16'h00A0, 8'h81); rd(16'h00A0, v); chk("R4 secondary in-service", v, 8'h10);
    wr(16'h00A0, 8'h20); wr(16'h0020, 8'h20);
    wr(16'h00A0, 8'h80); wr(16'h0020, 8'h80);
    irq_in[12] = 1'b0;
    step();

    // R6 spurious secondary
    wr(16'h04D1, 8'h02);
    irq_in[9] = 1'b1;
    step(); step();
    chk("R6 cascade raised", {7'd0, cpu_int}, 8'h01);
    irq_in[9] = 1'b0;
    step();
    ack(v); chk("R6 spurious secondary", v, 8'h77);
    wr(16'h00A0, 8'h81); rd(16'h00A0, v); chk("R6 secondary unchanged", v, 8'h00);
    wr(16'h00A0, 8'h80);
    wr(16'h0020, 8'h20);
    wr(16'h04D1, 8'h00);

    // R8 level mode
    wr(16'h04D0, 8'h08);
    irq_in[3] = 1'b1;
    step();
    ack(v); chk("R8 level vector", v, 8'h0B);
    rd(16'h0020, v); chk("R8 level stays pending", v, 8'h08);
    wr(16'h0020, 8'h20);
    chk("R8 level reasserts", {7'd0, cpu_int}, 8'h01);
    irq_in[3] = 1'b0;
    step();
    chk("R8 level drops", {7'd0, cpu_int}, 8'h00);
    wr(16'h04D0, 8'h00);

    // R12 poll
    irq_in[6] = 1'b1;
    step();
    wr(16'h0020, 8'hC0); rd(16'h0020, v); chk("R12 poll hit", v, 8'h86);
    rd(16'h0020, v); chk("R12 poll cleared pending", v, 8'h00);
    wr(16'h0020, 8'hC0); rd(16'h0020, v); chk("R12 poll empty", v, 8'h07);
    irq_in[6] = 1'b0;
    irq_in[13] = 1'b1;
    step(); step();
    wr(16'h00A0, 8'hC0); rd(16'h00A0, v); chk("R12 secondary poll", v, 8'h85);
    rd(16'h0020, v); chk("R12 primary line 2 cleared", v, 8'h00);
    chk("R12 cpu_int after poll", {7'd0, cpu_int}, 8'h00);
    irq_in[13] = 1'b0;
    step();

    // R13 base change
    wr(16'h0020, 8'h44);
    irq_in[1] = 1'b1;
    step();
    ack(v); chk("R13 new base", v, 8'h21);
    wr(16'h0020, 8'h41);
    wr(16'h0020, 8'h20);
    irq_in[1] = 1'b0;
    step();

    // R10 specific EOI
    irq_in[6] = 1'b1;
    step();
    ack(v); chk("R10 line 6 vector", v, 8'h0E);
    irq_in[4] = 1'b1;
    step();
    chk("R10 higher line preempts", {7'd0, cpu_int}, 8'h01);
    ack(v); chk("R10 line 4 vector", v, 8'h0C);
    wr(16'h0020, 8'h66);
    wr(16'h0020, 8'h81); rd(16'h0020, v); chk("R10 specific EOI", v, 8'h10);
    wr(16'h0020, 8'h20); rd(16'h0020, v); chk("R10 non-specific EOI", v, 8'h00);
    irq_in[6] = 1'b0; irq_in[4] = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule